// File: doc/BRIEF.md
# Self-Timed Byte Programming Controller with Write Status Polling

This block sits between a host programming port and a parallel flash array that is written one byte at a time. The host places an address and a data byte on its inputs and then pulses a program strobe. If the high-voltage enable input is present and the lock input is clear, the controller latches the address and byte and issues one write pulse to the array. It then holds a busy indication for a fixed, self-timed number of clock cycles. By default this number matches 50 microseconds at the configured clock frequency.

While the write runs, the host may keep reading. A read of the address being written returns the written byte with bit 7 inverted. The host can poll that bit to learn when the cycle has ended. Reads of any other address pass the array contents through unchanged. Once the busy window closes, all reads return true data and a new write can be started. A strobe that arrives during a write is dropped, and it raises a sticky error flag that only reset clears.

Top module: `byte_prog_ctrl`

## Requirements
- R1: After reset, `busy`, `memWrPulse` and `errSticky` are 0, and `hostDataOut` is 0 while `readEn` is 0.
- R2: A 0-to-1 transition of `progStrobe` that is sampled on a clock edge while idle, with `hvEnable`=1 and `lockIn`=0, makes `memWrPulse` high for exactly the next cycle. During that cycle `memWrAddr` and `memWrData` carry the `hostAddr` and `hostDataIn` values sampled at that edge.
- R3: `busy` is high for exactly `WRITE_CYCLES` consecutive cycles, starting with the write-pulse cycle.
- R4: A strobe transition while `hvEnable`=0 produces no write pulse and no busy window, and the array keeps its contents.
- R5: A strobe transition while `lockIn`=1 produces no write pulse and no busy window, and the array keeps its contents.
- R6: A strobe transition while busy starts no write and does not alter the array. It sets `errSticky`, which stays at 1 until reset.
- R7: While busy, a read (`readEn`=1) of the address being written returns the written byte with bit 7 inverted and bits 6..0 unchanged.
- R8: While busy, a read of any other address returns `memRdData` for that address unchanged.
- R9: After busy falls, a read of the written address returns the written byte, and a new strobe starts a new write.
- R10: With `readEn`=0, `hostDataOut` is 0.
- R11: A strobe held high across many cycles starts only one write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostAddr | input | ADDR_W | Host address for reads and writes |
| hostDataIn | input | 8 | Byte to program |
| hostDataOut | output | 8 | Read data or polling status |
| progStrobe | input | 1 | Program strobe; the rising edge requests a write |
| readEn | input | 1 | Host read enable |
| hvEnable | input | 1 | High-voltage program enable present |
| lockIn | input | 1 | Programming lock; blocks new writes |
| errSticky | output | 1 | Strobe seen during a write; cleared by reset |
| busy | output | 1 | Self-timed write in progress |
| memRdAddr | output | ADDR_W | Array read address |
| memRdData | input | 8 | Array read data |
| memWrAddr | output | ADDR_W | Array write address |
| memWrData | output | 8 | Array write data |
| memWrPulse | output | 1 | One-cycle array write strobe |

## Verification
The bench measures the length of the busy window against `WRITE_CYCLES`. A counter that is off by one would make the window one cycle short or long. During a write it reads both the address being written and an unrelated address. A design that inverted the wrong bit, or applied the inversion to every address, would return mismatching bytes. It raises a second strobe in the middle of a write, then reads the address that strobe carried to confirm that nothing was written, and confirms that the error flag rises and stays set. It also holds the strobe high through an entire write. A level-triggered design would start a second write, which shows up as busy rising again.

// File: rtl/bwc_pkg.sv
package bwc_pkg;
  typedef struct packed {
    logic capture;
    logic wrPulse;
    logic busy;
  } bwc_strobe_t;
endpackage

// File: rtl/bwc_ctrl.sv
module bwc_ctrl
  import bwc_pkg::*;
#(
  parameter int WRITE_CYCLES = 12500,
  parameter int CNT_W = $clog2(WRITE_CYCLES + 1)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        progStrobe,
  input  logic        hvEnable,
  input  logic        lockIn,
  output bwc_strobe_t ctrl,
  output logic        errSticky
);
  typedef enum logic {S_IDLE, S_WRITE} state_t;

  state_t     state;
  logic       strobeQ;
  logic       pulseQ;
  logic [CNT_W-1:0] cnt;
  logic       strobeRise;
  logic       startOk;

  assign strobeRise = progStrobe & ~strobeQ;
  assign startOk    = strobeRise && (state == S_IDLE) && hvEnable && !lockIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      strobeQ   <= 1'b0;
      pulseQ    <= 1'b0;
      cnt       <= '0;
      errSticky <= 1'b0;
    end else begin
      strobeQ <= progStrobe;
      pulseQ  <= startOk;
      case (state)
        S_IDLE: begin
          if (startOk) begin
            state <= S_WRITE;
            cnt   <= CNT_W'(WRITE_CYCLES - 1);
          end
        end
        S_WRITE: begin
          if (cnt == '0) state <= S_IDLE;
          else           cnt   <= cnt - 1'b1;
          if (strobeRise) errSticky <= 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    ctrl.capture = startOk;
    ctrl.wrPulse = pulseQ;
    ctrl.busy    = (state == S_WRITE);
  end

  // R2: the write pulse never lasts more than one cycle
  a_r2_pulse_single: assert property (@(posedge clk) disable iff (!rstN)
    pulseQ |=> !pulseQ);
  // R2/R3: a pulse only appears in the first cycle of a new busy window
  a_r3_pulse_opens_window: assert property (@(posedge clk) disable iff (!rstN)
    pulseQ |-> (state == S_WRITE) && $past(state == S_IDLE));
  // R4, R5: a write was only launched with enable present and lock clear
  a_r4_r5_start_gated: assert property (@(posedge clk) disable iff (!rstN)
    pulseQ |-> ($past(hvEnable) && !$past(lockIn)));
  // R6: error flag is sticky
  a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    errSticky |=> errSticky);
  // R6: error flag only rises out of a write in progress
  a_r6_err_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errSticky) |-> $past(state == S_WRITE));
  // R3: countdown stays within the window
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WRITE) |-> (cnt < CNT_W'(WRITE_CYCLES)));
endmodule

// File: rtl/bwc_datapath.sv
module bwc_datapath
  import bwc_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  bwc_strobe_t       ctrl,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [7:0]        hostDataIn,
  input  logic              readEn,
  output logic [7:0]        hostDataOut,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic [7:0]        memRdData,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [7:0]        memWrData
);
  logic [ADDR_W-1:0] lastAddr;
  logic [7:0]        lastData;
  logic              pollHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastAddr <= '0;
      lastData <= '0;
    end else if (ctrl.capture) begin
      lastAddr <= hostAddr;
      lastData <= hostDataIn;
    end
  end

  assign memRdAddr = hostAddr;
  assign memWrAddr = lastAddr;
  assign memWrData = lastData;
  assign pollHit   = ctrl.busy && (hostAddr == lastAddr);

  always_comb begin
    if (!readEn)      hostDataOut = 8'h00;
    else if (pollHit) hostDataOut = {~lastData[7], lastData[6:0]};
    else              hostDataOut = memRdData;
  end

  // R2: latched address and byte hold still for the whole write
  a_r2_capture_stable: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.busy && !ctrl.capture) |=> ($stable(lastAddr) && $stable(lastData)));
  // R10: idle read port drives zero
  a_r10_quiet_out: assert property (@(posedge clk) disable iff (!rstN)
    !readEn |-> (hostDataOut == 8'h00));
endmodule

// File: rtl/byte_prog_ctrl.sv
module byte_prog_ctrl
  import bwc_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int CLK_MHZ      = 250,
  parameter int WRITE_US     = 50,
  parameter int WRITE_CYCLES = CLK_MHZ * WRITE_US
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [7:0]        hostDataIn,
  output logic [7:0]        hostDataOut,
  input  logic              progStrobe,
  input  logic              readEn,
  input  logic              hvEnable,
  input  logic              lockIn,
  output logic              errSticky,
  output logic              busy,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic [7:0]        memRdData,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [7:0]        memWrData,
  output logic              memWrPulse
);
  localparam int CNT_W = $clog2(WRITE_CYCLES + 1);

  bwc_strobe_t ctrl;

  bwc_ctrl #(.WRITE_CYCLES(WRITE_CYCLES), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .progStrobe(progStrobe), .hvEnable(hvEnable),
    .lockIn(lockIn), .ctrl(ctrl), .errSticky(errSticky)
  );

  bwc_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .hostAddr(hostAddr),
    .hostDataIn(hostDataIn), .readEn(readEn), .hostDataOut(hostDataOut),
    .memRdAddr(memRdAddr), .memRdData(memRdData), .memWrAddr(memWrAddr),
    .memWrData(memWrData)
  );

  assign busy       = ctrl.busy;
  assign memWrPulse = ctrl.wrPulse;

  // R3: busy only rises together with a write pulse
  a_r3_busy_rise_pulse: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> memWrPulse);
endmodule

// File: tb/tb_byte_prog_ctrl.sv
`timescale 1ns/1ps
module tb_byte_prog_ctrl;
  localparam int ADDR_W = 6;
  localparam int WC     = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [ADDR_W-1:0] hostAddr = '0;
  logic [7:0] hostDataIn = '0;
  logic [7:0] hostDataOut;
  logic progStrobe = 1'b0, readEn = 1'b0, hvEnable = 1'b1, lockIn = 1'b0;
  logic errSticky, busy, memWrPulse;
  logic [ADDR_W-1:0] memRdAddr, memWrAddr;
  logic [7:0] memRdData, memWrData;
  logic [7:0] mem [0:(1<<ADDR_W)-1];

  int nRun = 0, nFail = 0, busyLen = 0;
  logic [7:0] expQ[$];
  string reqQ[$];

  always #2 clk = ~clk;

  byte_prog_ctrl #(.ADDR_W(ADDR_W), .WRITE_CYCLES(WC)) dut (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostDataIn(hostDataIn),
    .hostDataOut(hostDataOut), .progStrobe(progStrobe), .readEn(readEn),
    .hvEnable(hvEnable), .lockIn(lockIn), .errSticky(errSticky), .busy(busy),
    .memRdAddr(memRdAddr), .memRdData(memRdData), .memWrAddr(memWrAddr),
    .memWrData(memWrData), .memWrPulse(memWrPulse)
  );

  assign memRdData = mem[memRdAddr];
  always @(posedge clk) if (memWrPulse) mem[memWrAddr] <= memWrData;

  function automatic logic [7:0] initVal(int a);
    return 8'((a * 3) + 5);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // busy-length tracker
  always @(negedge clk) if (busy) busyLen++;

  // scoreboard monitor
  initial forever begin
    @(negedge clk); #1;
    if (readEn && expQ.size() > 0) check(reqQ.pop_front(), hostDataOut, expQ.pop_front());
  end

  task automatic readExp(logic [ADDR_W-1:0] a, logic [7:0] e, string req);
    @(negedge clk);
    hostAddr = a; readEn = 1'b1;
    expQ.push_back(e); reqQ.push_back(req);
  endtask

  task automatic readOff();
    @(negedge clk); readEn = 1'b0;
  endtask

  task automatic startWrite(logic [ADDR_W-1:0] a, logic [7:0] d);
    @(negedge clk);
    busyLen = 0;
    hostAddr = a; hostDataIn = d; progStrobe = 1'b1;
    @(negedge clk); #1;
    progStrobe = 1'b0;
    check("R2 pulse", memWrPulse, 1);
    check("R2 addr", memWrAddr, a);
    check("R2 data", memWrData, d);
    check("R3 busy start", busy, 1);
  endtask

  task automatic waitIdle();
    while (busy) begin @(negedge clk); #1; end
    check("R3 busy length", busyLen, WC);
  endtask

  initial begin
    for (int i = 0; i < (1<<ADDR_W); i++) mem[i] = initVal(i);
    #20000;
    nFail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R1 busy", busy, 0);
    check("R1 pulse", memWrPulse, 0);
    check("R1 err", errSticky, 0);
    check("R10 out idle", hostDataOut, 0);
    rstN = 1'b1;

    // normal write with polling
    startWrite(6'd5, 8'hA7);
    readExp(6'd5, 8'h27, "R7 poll");
    readExp(6'd9, initVal(9), "R8 other addr");
    readOff();
    #1 check("R10 out readEn low", hostDataOut, 0);
    waitIdle();
    readExp(6'd5, 8'hA7, "R9 true data");
    readOff();

    // write with bit7 clear, back to back
    startWrite(6'd12, 8'h3C);
    readExp(6'd12, 8'hBC, "R7 poll bit7 low");
    readOff();
    waitIdle();
    readExp(6'd12, 8'h3C, "R9 second write");
    readOff();

    // R4: no high voltage
    hvEnable = 1'b0;
    @(negedge clk); hostAddr = 6'd7; hostDataIn = 8'h55; progStrobe = 1'b1;
    @(negedge clk); #1;
    check("R4 no pulse", memWrPulse, 0);
    check("R4 no busy", busy, 0);
    progStrobe = 1'b0; hvEnable = 1'b1;
    readExp(6'd7, initVal(7), "R4 array kept");
    readOff();

    // R5: locked
    lockIn = 1'b1;
    @(negedge clk); hostAddr = 6'd8; hostDataIn = 8'h66; progStrobe = 1'b1;
    @(negedge clk); #1;
    check("R5 no pulse", memWrPulse, 0);
    check("R5 no busy", busy, 0);
    progStrobe = 1'b0; lockIn = 1'b0;
    readExp(6'd8, initVal(8), "R5 array kept");
    readOff();

    // R11: strobe held high through a whole write
    @(negedge clk);
    busyLen = 0;
    hostAddr = 6'd20; hostDataIn = 8'h81; progStrobe = 1'b1;
    @(negedge clk); #1;
    check("R11 first pulse", memWrPulse, 1);
    waitIdle();
    repeat (5) begin @(negedge clk); #1; check("R11 no restart", busy, 0); end
    progStrobe = 1'b0;
    check("R11 err untouched", errSticky, 0);
    readExp(6'd20, 8'h81, "R11 data");
    readOff();

    // R6: strobe during a write
    startWrite(6'd30, 8'h11);
    @(negedge clk); hostAddr = 6'd31; hostDataIn = 8'hEE; progStrobe = 1'b1;
    @(negedge clk); #1;
    check("R6 no pulse", memWrPulse, 0);
    check("R6 err set", errSticky, 1);
    progStrobe = 1'b0;
    waitIdle();
    readExp(6'd31, initVal(31), "R6 array kept");
    readExp(6'd30, 8'h11, "R9 after ignored strobe");
    readOff();
    repeat (3) @(negedge clk);
    #1 check("R6 err sticky", errSticky, 1);

    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule